// File: doc/BRIEF.md
# Parallel Flash Command and Status Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. It accepts one request at a time: program one word, erase one sector, or erase the whole array. For each request it plays out the fixed unlock-and-command write script that the flash needs, generating chip-select, write-enable and output-enable with setup, pulse and recovery lengths counted in clock cycles. It then reads the target location repeatedly until bit 7 of every byte lane shows its final value. If the limit for that operation type runs out first, it pulses the flash reset line, waits for the part to recover, and reports an error.

Requests arrive on a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low through the cycle that carries the response, so a host holding `req_valid` high is simply stalled. The response is a one-cycle `rsp_valid` pulse with `rsp_err`. It has no back-pressure, so the host must be able to take it in any cycle. All flash-side outputs are registered.

Top module: `flash_seq`

## Requirements
- R1: Program (`req_op`=00) issues four write cycles in this order: AAh@5555h, 55h@2AAAh, A0h@5555h, then `req_data`@`req_addr`. Every command byte is repeated in each byte lane of the data bus (AAh becomes AAAAh on a 16-bit bus).
- R2: Sector erase (`req_op`=01) issues six write cycles: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h@`req_addr`.
- R3: Chip erase (`req_op`=10) issues the same first five write cycles as R2, and its sixth write is 10h@5555h.
- R4: Within a write cycle, chip-select goes low at least SETUP_CYC cycles before write-enable falls. Write-enable stays low for exactly WE_LOW_CYC cycles and high for at least WE_HIGH_CYC cycles between pulses. Address and data are stable while chip-select is low. Output-enable is never low together with write-enable.
- R5: `req_ready` is high only when idle and stays low from acceptance through the response cycle. `rsp_valid` is a single-cycle pulse, and there is exactly one response per accepted request.
- R6: After the last command write, reads at `req_addr` repeat until, in every byte lane, bit 7 equals that lane's bit 7 of `req_data` (program) or 1 (erase). The sequencer then responds with `rsp_err`=0.
- R7: Polling stops with `rsp_err`=1 at the first read that completes at least PROG_TO, SECT_TO or CHIP_TO cycles (chosen by operation type) after the last command write.
- R8: On timeout, `fl_rst_n` is held low for at least RST_CYC cycles with the bus idle. The response follows no earlier than RDY_CYC cycles after `fl_rst_n` returns high.
- R9: `req_op`=11 is answered with `rsp_err`=1 and causes no flash bus cycle.
- R10: While reset is active and after it is released: `req_ready`=1, `fl_ce_n`=`fl_we_n`=`fl_oe_n`=`fl_rst_n`=1, `fl_drive`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 invalid |
| req_addr | input | AW | Target word or sector address |
| req_data | input | DW | Word to program |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Timeout or invalid operation, valid with rsp_valid |
| fl_addr | output | AW | Flash address bus |
| fl_wdata | output | DW | Data driven toward the flash |
| fl_drive | output | 1 | High when the host drives the data bus |
| fl_rdata | input | DW | Data read from the flash |
| fl_ce_n | output | 1 | Chip select, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_rst_n | output | 1 | Flash reset, active low |

## Verification
Every bus event follows from an exact count of registers:

- Chip-select falls one cycle after the internal start pulse.
- Write-enable falls SETUP_CYC cycles after that and rises WE_LOW_CYC cycles later.
- A read samples `fl_rdata` on the edge where output-enable returns high, OE_GAP_CYC + READ_CYC cycles after chip-select falls.
- The reset pulse lasts RST_CYC+1 cycles, and the response arrives RDY_CYC+1 cycles after its release.

The bench samples every output on the falling clock edge and measures these spans with cycle stamps rather than fixed waits. Pulse widths, setup and recovery are checked as bounds, and the timeout is checked as a window of one read cycle above the configured limit. A bench flash model returns the inverse of bit 7 for a set number of reads, so the number of polling reads is checked exactly.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_BAD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_POLL,
    ST_RST,
    ST_WAIT,
    ST_RSP
  } st_e;
endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
  import flash_seq_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data,
  output logic          c_last
);
  localparam int LANES = DW / 8;
  localparam logic [AW-1:0] ADR_A = AW'(16'h5555);
  localparam logic [AW-1:0] ADR_B = AW'(16'h2AAA);

  function automatic logic [DW-1:0] rep(input logic [7:0] b);
    return {LANES{b}};
  endfunction

  always_comb begin
    c_addr = ADR_A;
    c_data = rep(8'hAA);
    c_last = 1'b0;
    if (op == OP_PROG) begin
      case (step)
        3'd0: begin c_addr = ADR_A; c_data = rep(8'hAA); end
        3'd1: begin c_addr = ADR_B; c_data = rep(8'h55); end
        3'd2: begin c_addr = ADR_A; c_data = rep(8'hA0); end
        default: begin c_addr = tgt_addr; c_data = tgt_data; c_last = 1'b1; end
      endcase
    end else begin
      case (step)
        3'd0: begin c_addr = ADR_A; c_data = rep(8'hAA); end
        3'd1: begin c_addr = ADR_B; c_data = rep(8'h55); end
        3'd2: begin c_addr = ADR_A; c_data = rep(8'h80); end
        3'd3: begin c_addr = ADR_A; c_data = rep(8'hAA); end
        3'd4: begin c_addr = ADR_B; c_data = rep(8'h55); end
        default: begin
          c_last = 1'b1;
          if (op == OP_CHIP) begin
            c_addr = ADR_A;
            c_data = rep(8'h10);
          end else begin
            c_addr = tgt_addr;
            c_data = rep(8'h30);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_bus_eng.sv
module flash_bus_eng #(
  parameter int AW          = 21,
  parameter int DW          = 16,
  parameter int SETUP_CYC   = 1,
  parameter int WE_LOW_CYC  = 3,
  parameter int WE_HIGH_CYC = 1,
  parameter int OE_GAP_CYC  = 1,
  parameter int READ_CYC    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          done,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_drive,
  input  logic [DW-1:0] fl_rdata,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int CW = $clog2(SETUP_CYC + WE_LOW_CYC + WE_HIGH_CYC + OE_GAP_CYC + READ_CYC + 1);

  typedef enum logic [2:0] {E_IDLE, E_SETUP, E_LOW, E_HIGH, E_GAP, E_RD} eng_e;

  eng_e          st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= E_IDLE;
      cnt      <= '0;
      done     <= 1'b0;
      rdata_o  <= '0;
      fl_addr  <= '0;
      fl_wdata <= '0;
      fl_drive <= 1'b0;
      fl_ce_n  <= 1'b1;
      fl_we_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: if (start) begin
          fl_addr <= addr_i;
          fl_ce_n <= 1'b0;
          if (rd) begin
            st       <= E_GAP;
            cnt      <= CW'(OE_GAP_CYC - 1);
            fl_drive <= 1'b0;
          end else begin
            st       <= E_SETUP;
            cnt      <= CW'(SETUP_CYC - 1);
            fl_wdata <= data_i;
            fl_drive <= 1'b1;
          end
        end
        E_SETUP: if (cnt == '0) begin
          fl_we_n <= 1'b0;
          cnt     <= CW'(WE_LOW_CYC - 1);
          st      <= E_LOW;
        end else cnt <= cnt - 1'b1;
        E_LOW: if (cnt == '0) begin
          fl_we_n <= 1'b1;
          cnt     <= CW'(WE_HIGH_CYC - 1);
          st      <= E_HIGH;
        end else cnt <= cnt - 1'b1;
        E_HIGH: if (cnt == '0) begin
          fl_ce_n  <= 1'b1;
          fl_drive <= 1'b0;
          done     <= 1'b1;
          st       <= E_IDLE;
        end else cnt <= cnt - 1'b1;
        E_GAP: if (cnt == '0) begin
          fl_oe_n <= 1'b0;
          cnt     <= CW'(READ_CYC - 1);
          st      <= E_RD;
        end else cnt <= cnt - 1'b1;
        E_RD: if (cnt == '0) begin
          rdata_o <= fl_rdata;
          fl_oe_n <= 1'b1;
          fl_ce_n <= 1'b1;
          done    <= 1'b1;
          st      <= E_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= E_IDLE;
      endcase
    end
  end

  // R4
  we_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) !fl_we_n |-> !fl_ce_n);
  // R4
  we_oe_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!fl_we_n && !fl_oe_n));
  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_wdata)));
  // R4
  drive_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) fl_drive |-> !fl_ce_n);
endmodule

// File: rtl/flash_timer.sv
module flash_timer #(
  parameter int TW = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= '0;
    else if (cnt != '1)    cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int          AW          = 21,
  parameter int          DW          = 16,
  parameter int          SETUP_CYC   = 1,
  parameter int          WE_LOW_CYC  = 3,
  parameter int          WE_HIGH_CYC = 1,
  parameter int          OE_GAP_CYC  = 1,
  parameter int          READ_CYC    = 5,
  parameter logic [39:0] PROG_TO     = 40'd15000,
  parameter logic [39:0] SECT_TO     = 40'd750000000,
  parameter logic [39:0] CHIP_TO     = 40'd12800000000,
  parameter logic [39:0] RST_CYC     = 40'd25,
  parameter logic [39:0] RDY_CYC     = 40'd1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_drive,
  input  logic [DW-1:0] fl_rdata,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          fl_rst_n
);
  localparam int LANES = DW / 8;
  localparam int TW    = $clog2(CHIP_TO + 40'd1) + 1;

  st_e           st;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    step;
  logic          err_q;
  logic          rst_q;
  logic          bus_start;
  logic          bus_done;
  logic [DW-1:0] bus_rdata;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_data;
  logic          rom_last;
  logic          tmr_load;
  logic [TW-1:0] tmr_limit;
  logic          tmr_exp;
  logic [DW-1:0] exp_word;
  logic [LANES-1:0] lane_ok;
  logic          match;

  flash_cmd_rom #(.AW(AW), .DW(DW)) u_rom (
    .op(op_q), .step(step), .tgt_addr(addr_q), .tgt_data(data_q),
    .c_addr(rom_addr), .c_data(rom_data), .c_last(rom_last)
  );

  flash_bus_eng #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .WE_LOW_CYC(WE_LOW_CYC),
    .WE_HIGH_CYC(WE_HIGH_CYC), .OE_GAP_CYC(OE_GAP_CYC), .READ_CYC(READ_CYC)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .rd(st == ST_POLL),
    .addr_i((st == ST_POLL) ? addr_q : rom_addr), .data_i(rom_data),
    .done(bus_done), .rdata_o(bus_rdata),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_drive(fl_drive), .fl_rdata(fl_rdata),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  flash_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .limit(tmr_limit), .expired(tmr_exp)
  );

  // Expected final bit 7 per byte lane
  assign exp_word = (op_q == OP_PROG) ? data_q : '1;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_ok[l] = (bus_rdata[8*l+7] == exp_word[8*l+7]);
  end
  assign match = &lane_ok;

  always_comb begin
    case (st)
      ST_RST:  tmr_limit = TW'(RST_CYC);
      ST_WAIT: tmr_limit = TW'(RDY_CYC);
      default: begin
        case (op_q)
          OP_PROG: tmr_limit = TW'(PROG_TO);
          OP_SECT: tmr_limit = TW'(SECT_TO);
          default: tmr_limit = TW'(CHIP_TO);
        endcase
      end
    endcase
  end

  assign tmr_load = (st == ST_CMD  && bus_done && rom_last) ||
                    (st == ST_POLL && bus_done && !match && tmr_exp) ||
                    (st == ST_RST  && tmr_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      op_q      <= OP_PROG;
      addr_q    <= '0;
      data_q    <= '0;
      step      <= '0;
      err_q     <= 1'b0;
      rst_q     <= 1'b1;
      bus_start <= 1'b0;
    end else begin
      bus_start <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          step   <= '0;
          if (op_e'(req_op) == OP_BAD) begin
            err_q <= 1'b1;
            st    <= ST_RSP;
          end else begin
            err_q     <= 1'b0;
            bus_start <= 1'b1;
            st        <= ST_CMD;
          end
        end
        ST_CMD: if (bus_done) begin
          bus_start <= 1'b1;
          if (rom_last) st <= ST_POLL;
          else          step <= step + 1'b1;
        end
        ST_POLL: if (bus_done) begin
          if (match) begin
            err_q <= 1'b0;
            st    <= ST_RSP;
          end else if (tmr_exp) begin
            err_q <= 1'b1;
            rst_q <= 1'b0;
            st    <= ST_RST;
          end else begin
            bus_start <= 1'b1;
          end
        end
        ST_RST: if (tmr_exp) begin
          rst_q <= 1'b1;
          st    <= ST_WAIT;
        end
        ST_WAIT: if (tmr_exp) st <= ST_RSP;
        ST_RSP:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RSP);
  assign rsp_err   = err_q;
  assign fl_rst_n  = rst_q;

  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);
  // R5
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R8
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_rst_n |-> (fl_ce_n && fl_we_n && fl_oe_n));
  // R8
  rst_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n) !fl_rst_n |-> !rsp_valid);
endmodule

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int SETUP_CYC = 1, WE_LOW_CYC = 3, WE_HIGH_CYC = 1;
  localparam int PROG_TO = 200, SECT_TO = 400, CHIP_TO = 800, RST_CYC = 5, RDY_CYC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          rsp_valid, rsp_err;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata;
  logic          fl_drive, fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n;

  flash_seq #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC),
    .PROG_TO(40'(PROG_TO)), .SECT_TO(40'(SECT_TO)), .CHIP_TO(40'(CHIP_TO)),
    .RST_CYC(40'(RST_CYC)), .RDY_CYC(40'(RDY_CYC))
  ) u_flash_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_drive(fl_drive), .fl_rdata(fl_rdata),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_rst_n(fl_rst_n)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Flash model: returns busy_word for busy_left reads, then stat_word
  int            busy_left = 0;
  logic [DW-1:0] busy_word = '0, stat_word = '0;
  assign fl_rdata = (busy_left > 0) ? busy_word : stat_word;

  // Bus monitor, sampled on falling edge
  logic [AW-1:0] wa [0:7];
  logic [DW-1:0] wd [0:7];
  int n_wr, n_rd, n_rsp, lo_min, lo_max, hi_min, setup_min, lo_run, hi_run, ce_run;
  int rst_run, t_last_wr, t_rst_fall, t_rst_rise, t_rsp, ready_hi;
  logic [AW-1:0] rd_addr;
  logic last_err, in_op = 1'b0;
  logic prev_we = 1'b1, prev_oe = 1'b1, prev_rst = 1'b1;

  task automatic clear_log();
    n_wr = 0; n_rd = 0; n_rsp = 0; lo_min = 999; lo_max = 0; hi_min = 999; setup_min = 999;
    rst_run = 0; ready_hi = 0; rd_addr = '0; last_err = 1'b0;
    t_last_wr = 0; t_rst_fall = 0; t_rst_rise = 0; t_rsp = 0;
  endtask

  always @(negedge clk) begin
    if (prev_we && !fl_we_n) begin
      if (ce_run < setup_min) setup_min = ce_run;
      if (n_wr > 0 && hi_run < hi_min) hi_min = hi_run;
      lo_run = 0;
    end
    if (!fl_we_n) lo_run++;
    if (!prev_we && fl_we_n) begin
      if (lo_run < lo_min) lo_min = lo_run;
      if (lo_run > lo_max) lo_max = lo_run;
      if (n_wr < 8) begin wa[n_wr] = fl_addr; wd[n_wr] = fl_wdata; end
      n_wr++;
      t_last_wr = cyc;
      hi_run = 0;
    end
    if (fl_we_n) hi_run++;
    if (!prev_oe && fl_oe_n) begin
      n_rd++;
      rd_addr = fl_addr;
      if (busy_left > 0) busy_left--;
    end
    if (prev_rst && !fl_rst_n) t_rst_fall = cyc;
    if (!fl_rst_n) rst_run++;
    if (!prev_rst && fl_rst_n) t_rst_rise = cyc;
    if (rsp_valid) begin n_rsp++; last_err = rsp_err; t_rsp = cyc; end
    if (in_op && req_ready) ready_hi++;
    if (!fl_ce_n) ce_run++; else ce_run = 0;
    prev_we = fl_we_n; prev_oe = fl_oe_n; prev_rst = fl_rst_n;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input int maxc);
    clear_log();
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    in_op = 1'b1;
    for (int i = 0; i < maxc && n_rsp == 0; i++) @(posedge clk);
    in_op = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_pair(input string req, input int i, input logic [AW-1:0] a, input logic [DW-1:0] d);
    chk(wa[i] == a, req, $sformatf("write %0d address", i), longint'(wa[i]), longint'(a));
    chk(wd[i] == d, req, $sformatf("write %0d data", i), longint'(wd[i]), longint'(d));
  endtask

  task automatic chk_unlock5(input string req);
    chk_pair(req, 0, 21'h5555, 16'hAAAA);
    chk_pair(req, 1, 21'h2AAA, 16'h5555);
    chk_pair(req, 2, 21'h5555, 16'h8080);
    chk_pair(req, 3, 21'h5555, 16'hAAAA);
    chk_pair(req, 4, 21'h2AAA, 16'h5555);
  endtask

  task automatic t_reset();
    // R10
    chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    chk({fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n} == 4'hF, "R10", "strobes idle",
        {fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n}, 4'hF);
    chk(!fl_drive && !rsp_valid, "R10", "drive/rsp idle", {fl_drive, rsp_valid}, 0);
  endtask

  task automatic t_program();
    busy_left = 3; busy_word = 16'h3C5A ^ 16'h8080; stat_word = 16'h3C5A;
    run_op(2'b00, 21'h1ABCD, 16'h3C5A, 2000);
    chk(n_wr == 4, "R1", "program write count", n_wr, 4);
    chk_pair("R1", 0, 21'h5555, 16'hAAAA);
    chk_pair("R1", 1, 21'h2AAA, 16'h5555);
    chk_pair("R1", 2, 21'h5555, 16'hA0A0);
    chk_pair("R1", 3, 21'h1ABCD, 16'h3C5A);
    chk(lo_min == WE_LOW_CYC && lo_max == WE_LOW_CYC, "R4", "we low width", lo_max, WE_LOW_CYC);
    chk(hi_min >= WE_HIGH_CYC, "R4", "we high between pulses", hi_min, WE_HIGH_CYC);
    chk(setup_min >= SETUP_CYC, "R4", "ce before we setup", setup_min, SETUP_CYC);
    chk(n_rd == 4, "R6", "poll read count", n_rd, 4);
    chk(rd_addr == 21'h1ABCD, "R6", "poll address", rd_addr, 21'h1ABCD);
    chk(n_rsp == 1 && last_err == 1'b0, "R6", "program response ok", {n_rsp, last_err}, 2);
    chk(ready_hi == 0, "R5", "ready low while busy", ready_hi, 0);
  endtask

  task automatic t_sector();
    busy_left = 2; busy_word = 16'h0000; stat_word = 16'hFFFF;
    run_op(2'b01, 21'h0F0000, 16'h0000, 2000);
    chk(n_wr == 6, "R2", "sector erase write count", n_wr, 6);
    chk_unlock5("R2");
    chk_pair("R2", 5, 21'h0F0000, 16'h3030);
    chk(n_rd == 3 && !last_err, "R6", "erase poll ends on ones", n_rd, 3);
    chk(n_rsp == 1, "R5", "single response", n_rsp, 1);
  endtask

  task automatic t_chip();
    busy_left = 1; busy_word = 16'h7F7F; stat_word = 16'hFFFF;
    run_op(2'b10, 21'h000123, 16'h0000, 2000);
    chk(n_wr == 6, "R3", "chip erase write count", n_wr, 6);
    chk_unlock5("R3");
    chk_pair("R3", 5, 21'h5555, 16'h1010);
    chk(n_rsp == 1 && !last_err, "R3", "chip erase response", last_err, 0);
  endtask

  task automatic t_lane();
    // R6: only the upper lane is wrong at first; polling must continue
    busy_left = 2; busy_word = 16'h80FF ^ 16'h8000; stat_word = 16'h80FF;
    run_op(2'b00, 21'h000040, 16'h80FF, 2000);
    chk(n_rd == 3, "R6", "every lane must match", n_rd, 3);
    chk(!last_err, "R6", "lane response ok", last_err, 0);
  endtask

  task automatic t_timeout(input logic [1:0] op, input int lim, input string tag);
    busy_left = 1000000; busy_word = 16'h0000; stat_word = 16'h0000;
    run_op(op, 21'h000200, 16'hFFFF, 3000);
    chk(n_rsp == 1 && last_err, "R7", {tag, " timeout error"}, last_err, 1);
    chk((t_rst_fall - t_last_wr) >= lim && (t_rst_fall - t_last_wr) <= lim + 15, "R7",
        {tag, " timeout span"}, t_rst_fall - t_last_wr, lim);
    chk(rst_run >= RST_CYC, "R8", {tag, " reset width"}, rst_run, RST_CYC);
    chk((t_rsp - t_rst_rise) >= RDY_CYC, "R8", {tag, " recovery wait"}, t_rsp - t_rst_rise, RDY_CYC);
    busy_left = 0;
  endtask

  task automatic t_bad();
    run_op(2'b11, 21'h000010, 16'h1234, 50);
    chk(n_rsp == 1 && last_err, "R9", "invalid op error", last_err, 1);
    chk(n_wr == 0 && n_rd == 0, "R9", "invalid op bus quiet", n_wr + n_rd, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_log();
    lo_run = 0; hi_run = 0; ce_run = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_program();
    t_sector();
    t_chip();
    t_lane();
    t_timeout(2'b00, PROG_TO, "program");
    t_timeout(2'b01, SECT_TO, "sector");
    t_bad();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule